// File: doc/BRIEF.md
# Folded-Array Data Background Generator

This block turns a logical word address into the byte that a memory test engine should write, or expect to read back, so that the physical cell array holds a chosen data background. The target array folds its 8-bit words four ways into 32-cell rows. Bit `b` of word `w` is placed at physical column `4*b + (w mod 4)` of physical row `w / 4`. A constant byte per background would give the wrong physical picture. This block works out each bit from the cell that the folding places it in.

A test sequencer drives one request per clock: a word address, a background kind, an invert bit and a valid strobe. One cycle later the block returns the data byte with a matching valid flag. Write-0 and write-1 operations use the same background with the invert bit clear and set, so a single generator serves both polarities and the expected read data. The number of physical rows is a parameter.

Top module: `folded_bg_gen`

## Requirements
- R1: While reset is high, and on the first clock after it falls, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` equals the value that `in_valid` had on the previous clock edge, so the latency is exactly one cycle.
- R3: With `in_bg` = 0 (solid), every bit of `out_data` equals `in_inv`.
- R4: With `in_bg` = 1 (checkerboard), bit b of `out_data` equals (row parity XOR column parity XOR `in_inv`). The row is `in_addr / 4` and the column is `4*b + (in_addr mod 4)`, so physical row 0 reads 0101... from column 0.
- R5: With `in_bg` = 2 (row stripes), bit b of `out_data` equals (row parity XOR `in_inv`), using the row defined in R4.
- R6: With `in_bg` = 3 (column stripes), bit b of `out_data` equals (column parity XOR `in_inv`), using the column defined in R4.
- R7: A new request is accepted on every clock. Back-to-back requests with different addresses and kinds each produce their own correct byte, in order.
- R8: When `in_valid` is low, `out_data` keeps its last value whatever `in_addr`, `in_bg` and `in_inv` do.
- R9: For the same address and kind, setting `in_inv` complements every bit of the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_addr | input | ADDR_W (8) | Logical word address |
| in_bg | input | 2 | Background kind: 0 solid, 1 checkerboard, 2 row stripes, 3 column stripes |
| in_inv | input | 1 | Invert the background |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_data | output | WORD_W (8) | Data byte for the requested address |

## Verification
The bench sweeps addresses that cross several physical rows under every kind and both polarities. A design that took row parity from the low address bit, instead of from the bit above the fold, would give row stripes that alternate per word rather than per row, and the check would catch it. The bench also interleaves kinds and polarities in consecutive cycles, so a stale or wrongly delayed kind would show up as a mismatched byte. Idle cycles with moving address inputs reveal an output register that loads without the valid strobe.

// File: rtl/bgen_pkg.sv
package bgen_pkg;

    typedef enum logic [1:0] {
        BG_SOLID     = 2'd0,
        BG_CHECKER   = 2'd1,
        BG_ROWSTRIPE = 2'd2,
        BG_COLSTRIPE = 2'd3
    } bg_kind_e;

    typedef struct packed {
        bg_kind_e kind;
        logic     inv;
    } bg_mode_t;

    // Value of one physical cell for a given background and polarity.
    function automatic logic cell_value(
        input bg_kind_e kind,
        input logic     row_par,
        input logic     col_par,
        input logic     inv
    );
        logic base;
        case (kind)
            BG_SOLID:     base = 1'b0;
            BG_CHECKER:   base = row_par ^ col_par;
            BG_ROWSTRIPE: base = row_par;
            BG_COLSTRIPE: base = col_par;
            default:      base = 1'b0;
        endcase
        return base ^ inv;
    endfunction

endpackage

// File: rtl/bgen_locate.sv
// Maps a logical word address onto the physical row and the physical
// column of each of its bits, and reports their parities.
module bgen_locate #(
    parameter int ADDR_W = 8,
    parameter int FOLD   = 4,
    parameter int WORD_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              row_par,
    output logic [WORD_W-1:0] col_par
);
    localparam int SEL_W = $clog2(FOLD);
    localparam int COL_W = $clog2(FOLD * WORD_W);
    localparam int ROW_W = ADDR_W - SEL_W;

    logic [SEL_W-1:0] word_in_row;
    logic [ROW_W-1:0] row_idx;
    logic             unused_row_hi;

    assign word_in_row   = addr[SEL_W-1:0];
    assign row_idx       = addr[ADDR_W-1:SEL_W];
    assign row_par       = row_idx[0];
    assign unused_row_hi = ^row_idx;

    for (genvar b = 0; b < WORD_W; b++) begin : g_bitcol
        logic [COL_W-1:0] col_idx;
        assign col_idx    = COL_W'(FOLD * b) + COL_W'(word_in_row);
        assign col_par[b] = col_idx[0];
    end

endmodule

// File: rtl/bgen_pattern.sv
// Applies the selected background to every bit of the word.
module bgen_pattern
    import bgen_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  bg_mode_t          mode,
    input  logic              row_par,
    input  logic [WORD_W-1:0] col_par,
    output logic [WORD_W-1:0] data
);
    for (genvar b = 0; b < WORD_W; b++) begin : g_cell
        assign data[b] = cell_value(mode.kind, row_par, col_par[b], mode.inv);
    end
endmodule

// File: rtl/folded_bg_gen.sv
module folded_bg_gen
    import bgen_pkg::*;
#(
    parameter int ROWS   = 64,
    parameter int FOLD   = 4,
    parameter int WORD_W = 8,
    parameter int ADDR_W = $clog2(ROWS * FOLD)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [1:0]        in_bg,
    input  logic              in_inv,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);
    bg_mode_t          mode;
    logic              row_par;
    logic [WORD_W-1:0] col_par;
    logic [WORD_W-1:0] next_data;

    assign mode.kind = bg_kind_e'(in_bg);
    assign mode.inv  = in_inv;

    bgen_locate #(
        .ADDR_W (ADDR_W),
        .FOLD   (FOLD),
        .WORD_W (WORD_W)
    ) locate_i (
        .addr    (in_addr),
        .row_par (row_par),
        .col_par (col_par)
    );

    bgen_pattern #(
        .WORD_W (WORD_W)
    ) pattern_i (
        .mode    (mode),
        .row_par (row_par),
        .col_par (col_par),
        .data    (next_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= next_data;
            end
        end
    end

endmodule

// File: rtl/folded_bg_gen_chk.sv
module folded_bg_gen_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        in_bg,
    input logic              in_inv,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_data
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r3_solid_level: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_bg == 2'd0) |=> (out_data == {WORD_W{$past(in_inv)}}));

    a_r5_row_uniform: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_bg == 2'd2) |=> ($countones(out_data) == 0 || $countones(out_data) == WORD_W));

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
endmodule

bind folded_bg_gen folded_bg_gen_chk #(
    .WORD_W (WORD_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_bg     (in_bg),
    .in_inv    (in_inv),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/folded_bg_gen_tb_top.sv
module folded_bg_gen_tb_top;
    localparam int ADDR_W = 8;
    localparam int WORD_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [1:0]        in_bg = 2'd0;
    logic              in_inv = 1'b0;
    logic              out_valid;
    logic [WORD_W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    logic [WORD_W-1:0] exp_q[$];
    logic [WORD_W-1:0] last_data = '0;
    logic              mon_on = 1'b0;
    logic              done = 1'b0;

    always #2.5 clk = ~clk;

    folded_bg_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_addr   (in_addr),
        .in_bg     (in_bg),
        .in_inv    (in_inv),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // Reference model: per bit, physical row = addr/4, column = 4*b + addr%4.
    function automatic logic [WORD_W-1:0] model(input int addr, input int bg, input bit inv);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < WORD_W; b++) begin
            int row = addr / 4;
            int col = 4 * b + (addr % 4);
            bit v;
            case (bg)
                0: v = 0;
                1: v = ((row % 2) != (col % 2));
                2: v = (row % 2) == 1;
                default: v = (col % 2) == 1;
            endcase
            r[b] = v ^ inv;
        end
        return r;
    endfunction

    function automatic string req_tag(input int bg);
        case (bg)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input int addr, input int bg, input bit inv);
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = ADDR_W'(addr);
        in_bg    = 2'(bg);
        in_inv   = inv;
        exp_q.push_back(model(addr, bg, inv));
    endtask

    task automatic idle(input int addr, input int bg, input bit inv);
        @(negedge clk);
        in_valid = 1'b0;
        in_addr  = ADDR_W'(addr);
        in_bg    = 2'(bg);
        in_inv   = inv;
    endtask

    // Monitor: compares each valid result with the queue head; checks hold on idle cycles.
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected valid", 1'b1, 1'b0);
                end else begin
                    logic [WORD_W-1:0] e;
                    e = exp_q.pop_front();
                    check("R7 result", out_data, e);
                    last_data = out_data;
                end
            end else begin
                check("R8 hold while idle", out_data, last_data);
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {7'd0, out_valid}, 8'd0);
        check("R1 data in reset", out_data, 8'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", {7'd0, out_valid}, 8'd0);
        check("R1 data after reset", out_data, 8'd0);
        mon_on = 1'b1;

        // R3 R4 R5 R6 R9: sweep each kind and polarity over 16 physical rows.
        for (int bg = 0; bg < 4; bg++) begin
            for (int inv = 0; inv < 2; inv++) begin
                for (int a = 0; a < 64; a++) begin
                    drive(a, bg, inv[0]);
                end
            end
        end
        idle(0, 0, 0);
        idle(0, 0, 0);

        // R9: direct polarity pairs, checked against each other.
        for (int bg = 0; bg < 4; bg++) begin
            for (int a = 0; a < 8; a++) begin
                logic [WORD_W-1:0] p0;
                logic [WORD_W-1:0] p1;
                drive(a * 5, bg, 1'b0);
                @(negedge clk);
                in_valid = 1'b0;
                p0 = out_data;
                drive(a * 5, bg, 1'b1);
                @(negedge clk);
                in_valid = 1'b0;
                p1 = out_data;
                check({req_tag(bg), " R9 inversion"}, p1, ~p0);
            end
        end
        idle(0, 0, 0);

        // R7: back-to-back requests with mixed kinds, polarities and high addresses.
        for (int i = 0; i < 200; i++) begin
            drive((i * 37 + 11) % 256, (i * 3) % 4, (i % 3) == 1);
        end

        // R8: idle cycles with moving inputs, then resume.
        for (int i = 0; i < 20; i++) begin
            idle(i * 13, i % 4, i[0]);
        end
        drive(255, 1, 1'b0);
        idle(7, 3, 1'b1);
        idle(9, 2, 1'b1);
        idle(0, 0, 1'b0);

        check("R7 queue drained", 8'(exp_q.size()), 8'd0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule